// File: doc/BRIEF.md
# Event Wake-up Mask Register with Per-Line Access Filtering

This block stores one mask bit per event line and decides which lines may wake the processor with an event. Each registered wake-up output is the AND of that line's event input and its mask bit. A simple register port carries a write strobe with a write-data word and a read strobe with a read-data word. Each write carries a security attribute and a privilege attribute. Each read carries a security attribute.

Two configuration vectors come in from outside the block. One marks lines whose mask bit only secure accesses may touch. The other marks lines whose mask bit only privileged writes may change. Filtering is resolved bit by bit. One bus write can therefore update some mask bits and leave protected bits of the same word unchanged. Reads hide secure-only bits from non-secure callers by returning 0 in those positions.

A build parameter removes the optional upper lines (23 to 25 by default). Those positions then behave as reserved bits: they hold 0, ignore writes and never raise a wake-up. The register port is a plain strobe interface with no back-pressure. A write is always accepted in the cycle its strobe is high, and read data is valid in the same cycle as the read strobe.

Top module: `evt_wake_mask`

## Requirements
- R1: After reset every mask bit is 0. `wake_out` is 0 and a secure read returns 0.
- R2: `wake_out[x]` equals `evt_in[x] & mask[x]`, sampled at a clock edge and presented after that edge.
- R3: On a line with neither protection bit set, the mask bit takes `wr_data[x]` at the clock edge where `wr_en` is high, whatever the write attributes are. Bit x of every data word maps to line x.
- R4: On a line with `sec_only[x]=1`, a write with `wr_secure=0` leaves the mask bit unchanged. A write with `wr_secure=1` updates it, provided the privilege rule also allows the write.
- R5: On a line with `sec_only[x]=1`, a read with `rd_secure=0` returns 0 in bit x. A read with `rd_secure=1` returns the stored bit.
- R6: On a line with `priv_only[x]=1`, a write with `wr_priv=0` leaves the mask bit unchanged. Reads of that bit are not affected by this protection.
- R7: On a line with both protection bits set, a write takes effect only when `wr_secure=1` and `wr_priv=1`.
- R8: Within one write, each bit is filtered on its own. Allowed bits update and protected bits keep their old values.
- R9: When `HAS_OPT_LINES=0`, lines `OPT_FIRST` and above read 0, ignore every write and keep `wake_out` low.
- R10: A read in the same cycle as a write returns the value held before that write. The new value is visible from the next cycle.
- R11: While `rd_en` is 0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NUM_LINES | Write data, bit x for line x |
| wr_secure | input | 1 | Write is a secure access |
| wr_priv | input | 1 | Write is a privileged access |
| rd_en | input | 1 | Read strobe |
| rd_secure | input | 1 | Read is a secure access |
| rd_data | output | NUM_LINES | Filtered read data |
| sec_only | input | NUM_LINES | Per-line secure-only protection |
| priv_only | input | NUM_LINES | Per-line privileged-only protection |
| evt_in | input | NUM_LINES | Event inputs |
| wake_out | output | NUM_LINES | Registered gated wake-up events |

## Verification
The assertions check these behaviours on every cycle:
- A mask bit never changes unless a write was allowed for that bit.
- An allowed write stores its data bit.
- A non-secure read never shows a secure-only bit.
- `rd_data` stays 0 without a read strobe.
- Absent optional lines stay 0.
- `wake_out` always follows the previous cycle's event and mask.

Some behaviours only the bench scenarios can show, because each depends on a chosen sequence of stimuli. These are the reset value, mixed per-bit outcomes within one word, the old value returned by a read that collides with a write, and the reduced build running beside the full one.

// File: rtl/evtw_pkg.sv
package evtw_pkg;
  // Attributes carried by a write access
  typedef struct packed {
    logic secure;
    logic priv;
  } evtw_wr_attr_t;

  // Implemented-line vector: lines below first_opt always exist,
  // lines at or above it exist only when has_opt is set.
  function automatic logic [63:0] impl_lines(input int n, input int first_opt,
                                             input bit has_opt);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) v[i] = (i < first_opt) || has_opt;
    end
    return v;
  endfunction
endpackage

// File: rtl/evtw_access_filter.sv
module evtw_access_filter
  import evtw_pkg::*;
#(
  parameter int NUM_LINES = 26,
  parameter logic [NUM_LINES-1:0] IMPL = '1
) (
  input  logic                 wr_en,
  input  evtw_wr_attr_t        wr_attr,
  input  logic                 rd_secure,
  input  logic [NUM_LINES-1:0] sec_only,
  input  logic [NUM_LINES-1:0] priv_only,
  output logic [NUM_LINES-1:0] wr_bit_en,
  output logic [NUM_LINES-1:0] rd_visible
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (IMPL[i]) begin : g_impl
      logic sec_ok, priv_ok;
      assign sec_ok        = wr_attr.secure | ~sec_only[i];
      assign priv_ok       = wr_attr.priv   | ~priv_only[i];
      assign wr_bit_en[i]  = wr_en & sec_ok & priv_ok;
      assign rd_visible[i] = rd_secure | ~sec_only[i];
    end else begin : g_rsvd
      assign wr_bit_en[i]  = 1'b0;
      assign rd_visible[i] = 1'b0;
    end
  end

  // R7: a bit protected both ways accepts only secure privileged writes
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (wr_bit_en[i] && sec_only[i] && priv_only[i])
        p_dual_protect_r7: assert (wr_attr.secure && wr_attr.priv);
    end
  end
endmodule

// File: rtl/evtw_mask_reg.sv
module evtw_mask_reg #(
  parameter int NUM_LINES = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] wr_bit_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] mask_q
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mask_q[i] <= 1'b0;
      else if (wr_bit_en[i]) mask_q[i] <= wr_data[i];
    end
  end

  // R4 R6 R8: bits without a write enable keep their value
  p_hold_unwritten_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q ^ $past(mask_q)) & ~$past(wr_bit_en)) == '0);

  // R3: enabled bits take the write data
  p_store_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_bit_en) |=> (mask_q & $past(wr_bit_en)) == ($past(wr_data) & $past(wr_bit_en)));
endmodule

// File: rtl/evtw_wake_gate.sv
module evtw_wake_gate #(
  parameter int NUM_LINES = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] evt_in,
  input  logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] wake_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= '0;
    else        wake_q <= evt_in & mask_q;
  end

  // R2: output follows last cycle's event and mask
  p_wake_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wake_q == $past(evt_in & mask_q));
endmodule

// File: rtl/evt_wake_mask.sv
module evt_wake_mask
  import evtw_pkg::*;
#(
  parameter int NUM_LINES     = 26,
  parameter int OPT_FIRST     = 23,
  parameter bit HAS_OPT_LINES = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic                 wr_secure,
  input  logic                 wr_priv,
  input  logic                 rd_en,
  input  logic                 rd_secure,
  output logic [NUM_LINES-1:0] rd_data,
  input  logic [NUM_LINES-1:0] sec_only,
  input  logic [NUM_LINES-1:0] priv_only,
  input  logic [NUM_LINES-1:0] evt_in,
  output logic [NUM_LINES-1:0] wake_out
);
  localparam logic [63:0] IMPL_FULL = impl_lines(NUM_LINES, OPT_FIRST, HAS_OPT_LINES);
  localparam logic [NUM_LINES-1:0] IMPL = IMPL_FULL[NUM_LINES-1:0];

  evtw_wr_attr_t        wr_attr;
  logic [NUM_LINES-1:0] wr_bit_en;
  logic [NUM_LINES-1:0] rd_visible;
  logic [NUM_LINES-1:0] mask_q;

  assign wr_attr.secure = wr_secure;
  assign wr_attr.priv   = wr_priv;

  evtw_access_filter #(.NUM_LINES(NUM_LINES), .IMPL(IMPL)) u_filter (
    .wr_en      (wr_en),
    .wr_attr    (wr_attr),
    .rd_secure  (rd_secure),
    .sec_only   (sec_only),
    .priv_only  (priv_only),
    .wr_bit_en  (wr_bit_en),
    .rd_visible (rd_visible)
  );

  evtw_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_bit_en (wr_bit_en),
    .wr_data   (wr_data),
    .mask_q    (mask_q)
  );

  evtw_wake_gate #(.NUM_LINES(NUM_LINES)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .mask_q (mask_q),
    .wake_q (wake_out)
  );

  assign rd_data = rd_en ? (mask_q & rd_visible) : '0;

  // R5: non-secure reads never reveal secure-only bits
  p_nonsec_read_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_secure) |-> (rd_data & sec_only) == '0);

  // R11: idle read port drives zero
  p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  // R9: absent lines never hold a mask bit nor raise a wake-up
  p_absent_lines_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q | wake_out) & ~IMPL) == '0);
endmodule

// File: tb/evt_wake_mask_tb.sv
module evt_wake_mask_tb;
  localparam int N = 26;
  localparam logic [N-1:0] ABSENT = 26'h380_0000; // lines 23..25

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_secure = 1'b0, wr_priv = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic         rd_en = 1'b0, rd_secure = 1'b0;
  logic [N-1:0] sec_only = '0, priv_only = '0, evt_in = '0;
  logic [N-1:0] rd_data, wake_out, rd_data_l, wake_out_l;

  logic [N-1:0] exp_mask = '0;
  int tests = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  evt_wake_mask u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_secure(wr_secure), .wr_priv(wr_priv), .rd_en(rd_en), .rd_secure(rd_secure),
    .rd_data(rd_data), .sec_only(sec_only), .priv_only(priv_only),
    .evt_in(evt_in), .wake_out(wake_out));

  evt_wake_mask #(.HAS_OPT_LINES(1'b0)) u_dut_lite (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_secure(wr_secure), .wr_priv(wr_priv), .rd_en(rd_en), .rd_secure(rd_secure),
    .rd_data(rd_data_l), .sec_only(sec_only), .priv_only(priv_only),
    .evt_in(evt_in), .wake_out(wake_out_l));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; the bench model applies the per-line rules of R3/R4/R6/R7
  task automatic do_write(input logic [N-1:0] d, input logic s, input logic p);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_secure = s; wr_priv = p;
    for (int i = 0; i < N; i++)
      if ((s || !sec_only[i]) && (p || !priv_only[i])) exp_mask[i] = d[i];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic s, output logic [N-1:0] full, output logic [N-1:0] lite);
    @(negedge clk);
    rd_en = 1'b1; rd_secure = s;
    #1 full = rd_data; lite = rd_data_l;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [N-1:0] f, l;
    chk("R1 wake after reset", wake_out, '0);
    do_read(1'b1, f, l);
    chk("R1 mask after reset", f, '0);
    #1 chk("R11 idle read", rd_data, '0);
  endtask

  task automatic t_open_write;
    logic [N-1:0] f, l;
    sec_only = '0; priv_only = '0;
    do_write(26'h2A5_5A5A, 1'b0, 1'b0);
    do_read(1'b0, f, l);
    chk("R3 open write nonsec unpriv", f, 26'h2A5_5A5A);
    do_write(26'h15A_A5A5, 1'b1, 1'b1);
    do_read(1'b1, f, l);
    chk("R3 open write secure priv", f, 26'h15A_A5A5);
  endtask

  task automatic t_secure_lines;
    logic [N-1:0] f, l;
    sec_only = 26'h000_00FF; priv_only = '0;
    do_write('0, 1'b1, 1'b0);
    do_write(26'h3FF_FFFF, 1'b0, 1'b0);
    do_read(1'b1, f, l);
    chk("R4 nonsecure write blocked", f, 26'h3FF_FF00);
    do_write(26'h000_000F, 1'b1, 1'b0);
    do_read(1'b1, f, l);
    chk("R4 secure write accepted", f, 26'h000_000F);
    do_read(1'b0, f, l);
    chk("R5 nonsecure read hides secure bits", f, 26'h000_0000);
  endtask

  task automatic t_priv_lines;
    logic [N-1:0] f, l;
    sec_only = '0; priv_only = 26'h0F0_0000;
    do_write(26'h0A0_0000, 1'b0, 1'b1);
    do_write(26'h3FF_FFFF, 1'b1, 1'b0);
    do_read(1'b0, f, l);
    chk("R6 unpriv write blocked, read unaffected", f, 26'h3AF_FFFF);
  endtask

  task automatic t_both;
    logic [N-1:0] f, l;
    sec_only = 26'h000_0003; priv_only = 26'h000_0003;
    do_write('0, 1'b1, 1'b1);
    do_write(26'h000_0003, 1'b1, 1'b0);
    do_write(26'h000_0003, 1'b0, 1'b1);
    do_read(1'b1, f, l);
    chk("R7 partial attributes blocked", f & 26'h3, '0);
    do_write(26'h000_0001, 1'b1, 1'b1);
    do_read(1'b1, f, l);
    chk("R7 secure privileged write", f & 26'h3, 26'h1);
  endtask

  task automatic t_mixed_word;
    logic [N-1:0] f, l;
    sec_only = 26'h000_0F00; priv_only = 26'h00F_0000;
    do_write('0, 1'b1, 1'b1);
    do_write(26'h3FF_FFFF, 1'b0, 1'b1);
    do_read(1'b1, f, l);
    chk("R8 nonsecure mixed word", f, 26'h3FF_F0FF);
    do_write('0, 1'b1, 1'b0);
    do_read(1'b1, f, l);
    chk("R8 unpriv mixed word", f, 26'h00F_0000);
  endtask

  task automatic t_wake;
    sec_only = '0; priv_only = '0;
    do_write(26'h0F0_F0F0, 1'b1, 1'b1);
    @(negedge clk); evt_in = 26'h3FF_FFFF;
    @(negedge clk); chk("R2 all events gated", wake_out, 26'h0F0_F0F0);
    evt_in = 26'h333_3333;
    @(negedge clk); chk("R2 pattern events", wake_out, 26'h030_3030);
    evt_in = '0;
    @(negedge clk); chk("R2 no events", wake_out, '0);
  endtask

  task automatic t_rd_during_wr;
    sec_only = '0; priv_only = '0;
    do_write(26'h000_1234, 1'b1, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 26'h000_4321; wr_secure = 1'b1; wr_priv = 1'b1;
    rd_en = 1'b1; rd_secure = 1'b1;
    #1 chk("R10 read during write old value", rd_data, 26'h000_1234);
    exp_mask = 26'h000_4321;
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R10 new value next cycle", rd_data, 26'h000_4321);
    rd_en = 1'b0;
  endtask

  task automatic t_opt_absent;
    logic [N-1:0] f, l;
    sec_only = '0; priv_only = '0;
    do_write(26'h3FF_FFFF, 1'b1, 1'b1);
    do_read(1'b1, f, l);
    chk("R9 full build keeps lines 23-25", f, 26'h3FF_FFFF);
    chk("R9 lite build reserved lines read 0", l, 26'h3FF_FFFF & ~ABSENT);
    @(negedge clk); evt_in = ABSENT;
    @(negedge clk); chk("R9 lite no wake on absent lines", wake_out_l, '0);
    chk("R9 full wakes on lines 23-25", wake_out, ABSENT);
    evt_in = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_open_write();
    t_secure_lines();
    t_priv_lines();
    t_both();
    t_mixed_word();
    t_wake();
    t_rd_during_wr();
    t_opt_absent();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule